// File: doc/BRIEF.md
# Write-Back Data Cache with Critical-Word Refill

This block is a direct-mapped data cache between a single-issue CPU port and a lower-level memory that moves one 32-bit word per transaction. The cache holds `2^IDX_W` lines. Each line has `2^WOFF_W` words, a stored tag, a valid flag and a dirty flag. A 32-bit byte address is split as follows. Bits `[1:0]` are the byte offset and are ignored. The next `WOFF_W` bits select the word in the line. The next `IDX_W` bits pick the one line the block can live in. The remaining `32-(IDX_W+WOFF_W+2)` bits form the tag.

The cache serves hits in the same cycle and stalls the CPU on a miss. On a miss, it first copies a modified victim line back to memory. It then refills the line, starting with the word the CPU asked for. It releases the CPU in the cycle that word arrives and finishes the rest of the line in the background. Writes never go straight to memory. They land in the cache and mark the line dirty. A write miss fetches the line first and then merges the store into it. Two counters record accepted hits and detected misses, so the miss ratio can be measured.

Top module: `dcache_wb`

## Requirements
- R1: A read returns the most recent value written to that word address, whether the access hits or misses.
- R2: A hit (line valid and stored tag equal to the address tag) completes in the cycle it is presented, with `cpu_stall` low and no memory transaction started.
- R3: After reset no line is valid, so the first access to any address is a miss, and both counters read 0.
- R4: A new CPU request that arrives while the remaining words of a refill are still being fetched is held in stall until the line is complete, and then returns correct data.
- R5: A write hit updates only the cached word and marks the line dirty; the memory word keeps its previous value.
- R6: When a miss replaces a dirty line, all `2^WOFF_W` words of the old block are written to memory, at the old block's word addresses, before any word of the new block is read. A clean victim causes no write.
- R7: A write miss fetches the whole block, merges the written word into it, and leaves the line dirty, so later reads of the block see both the fetched words and the stored word.
- R8: Refill reads start at the requested word offset and continue upward modulo `2^WOFF_W`, for example 2, 3, 0, 1 for four-word lines.
- R9: On a miss the CPU is released in the cycle the requested word's memory transaction completes, with `cpu_rdata` equal to that word. It does not wait for the rest of the line.
- R10: `hit_count` increments by one for each hit accepted. `miss_count` increments by one for each miss detected, and a miss is not counted again when the held request later completes.
- R11: While `mem_req` is high and `mem_ready` is low, `mem_addr` and `mem_we` stay stable, and so does `mem_wdata` for writes. Each cycle with `mem_ready` high completes exactly one word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| cpu_req | input | 1 | CPU access request; must be held stable with its fields while stalled |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid in the cycle the access completes |
| cpu_stall | output | 1 | High while the presented access cannot complete |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 = write word to memory, 0 = read word |
| mem_addr | output | ADDR_W-2 | Word address |
| mem_wdata | output | 32 | Word written to memory |
| mem_ready | input | 1 | One-cycle completion of the current transaction |
| mem_rdata | input | 32 | Read data, valid when `mem_ready` is high |
| hit_count | output | CNT_W | Accepted hits |
| miss_count | output | CNT_W | Detected misses |

## Verification
The bench builds the cache with four lines of four words (`IDX_W=2`, `WOFF_W=2`). It confines CPU traffic to 64 word addresses, so each line competes among four tags. Conflict misses and dirty evictions are therefore frequent, and random offsets start the wraparound refill at every position. Its memory model answers after a fixed three-cycle latency. That leaves a window in which back-to-back requests land during the tail of a refill.

// File: rtl/cache_pkg.sv
package cache_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WB   = 2'd1,
    ST_FILL = 2'd2
  } ctl_state_e;
endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
  parameter int IDX_W = 4,
  parameter int TAG_W = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic             rd_dirty,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             ln_we,
  input  logic [IDX_W-1:0] ln_idx,
  input  logic             ln_valid,
  input  logic             ln_dirty,
  input  logic [TAG_W-1:0] ln_tag,
  input  logic             mark_dirty,
  input  logic [IDX_W-1:0] mark_idx
);
  localparam int LINES = 1 << IDX_W;

  logic             v_q [LINES];
  logic             d_q [LINES];
  logic [TAG_W-1:0] t_q [LINES];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic sel_ln, sel_mark;
    assign sel_ln   = ln_we && (ln_idx == IDX_W'(i));
    assign sel_mark = mark_dirty && (mark_idx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q[i] <= 1'b0;
        d_q[i] <= 1'b0;
      end else if (sel_ln) begin
        v_q[i] <= ln_valid;
        d_q[i] <= ln_dirty;
      end else if (sel_mark) begin
        d_q[i] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (sel_ln) t_q[i] <= ln_tag;
    end
  end

  assign rd_valid = v_q[rd_idx];
  assign rd_dirty = d_q[rd_idx];
  assign rd_tag   = t_q[rd_idx];
endmodule

// File: rtl/cache_data_store.sv
module cache_data_store
  import cache_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int WOFF_W = 2
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  ridx,
  input  logic [WOFF_W-1:0] roff,
  output logic [WORD_W-1:0] rdata,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [WOFF_W-1:0] woff,
  input  logic [WORD_W-1:0] wdata
);
  localparam int LINES = 1 << IDX_W;
  localparam int WORDS = 1 << WOFF_W;

  logic [WORD_W-1:0] arr_q [LINES][WORDS];

  for (genvar i = 0; i < LINES; i++) begin : g_row
    for (genvar j = 0; j < WORDS; j++) begin : g_col
      logic wen;
      assign wen = we && (widx == IDX_W'(i)) && (woff == WOFF_W'(j));
      always_ff @(posedge clk) begin
        if (wen) arr_q[i][j] <= wdata;
      end
    end
  end

  assign rdata = arr_q[ridx][roff];
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
  import cache_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int WOFF_W = 2,
  parameter int TAG_W  = 26,
  parameter int CNT_W  = 16,
  localparam int MADDR_W = TAG_W + IDX_W + WOFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_req,
  input  logic               cpu_we,
  input  logic [WORD_W-1:0]  cpu_wdata,
  input  logic [TAG_W-1:0]   a_tag,
  input  logic [IDX_W-1:0]   a_idx,
  input  logic [WOFF_W-1:0]  a_off,
  output logic [WORD_W-1:0]  cpu_rdata,
  output logic               cpu_stall,
  input  logic               lk_valid,
  input  logic               lk_dirty,
  input  logic [TAG_W-1:0]   lk_tag,
  output logic               ln_we,
  output logic [IDX_W-1:0]   ln_idx,
  output logic               ln_valid,
  output logic               ln_dirty,
  output logic [TAG_W-1:0]   ln_tag,
  output logic               mark_dirty,
  output logic [IDX_W-1:0]   d_ridx,
  output logic [WOFF_W-1:0]  d_roff,
  input  logic [WORD_W-1:0]  d_rdata,
  output logic               d_we,
  output logic [IDX_W-1:0]   d_widx,
  output logic [WOFF_W-1:0]  d_woff,
  output logic [WORD_W-1:0]  d_wdata,
  output logic               mem_req,
  output logic               mem_we,
  output logic [MADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0]  mem_wdata,
  input  logic               mem_ready,
  input  logic [WORD_W-1:0]  mem_rdata,
  output logic [CNT_W-1:0]   hit_count,
  output logic [CNT_W-1:0]   miss_count
);
  ctl_state_e        state_q, state_d;
  logic [TAG_W-1:0]  m_tag_q, v_tag_q;
  logic [IDX_W-1:0]  m_idx_q;
  logic [WOFF_W-1:0] m_off_q, beat_q, beat_d;
  logic              m_we_q;
  logic [WORD_W-1:0] m_wdata_q;
  logic [CNT_W-1:0]  hits_q, misses_q;

  logic lookup_hit, idle_hit, idle_miss, crit_beat, last_beat, latch_en, beat_en;
  logic [WOFF_W-1:0] fill_off;

  assign lookup_hit = lk_valid && (lk_tag == a_tag);
  assign idle_hit   = (state_q == ST_IDLE) && cpu_req && lookup_hit;
  assign idle_miss  = (state_q == ST_IDLE) && cpu_req && !lookup_hit;
  assign last_beat  = &beat_q;
  assign crit_beat  = (state_q == ST_FILL) && (beat_q == '0) && mem_ready;
  assign fill_off   = m_off_q + beat_q;
  assign latch_en   = idle_miss;
  assign beat_en    = (state_q != ST_IDLE) && mem_ready;

  // next-state logic
  always_comb begin
    state_d = state_q;
    beat_d  = beat_q;
    unique case (state_q)
      ST_IDLE: begin
        if (idle_miss) begin
          state_d = (lk_valid && lk_dirty) ? ST_WB : ST_FILL;
          beat_d  = '0;
        end
      end
      ST_WB: begin
        if (mem_ready) begin
          beat_d = beat_q + WOFF_W'(1);
          if (last_beat) state_d = ST_FILL;
        end
      end
      ST_FILL: begin
        if (mem_ready) begin
          beat_d = beat_q + WOFF_W'(1);
          if (last_beat) state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
    end else begin
      state_q <= state_d;
      if (latch_en || beat_en) beat_q <= beat_d;
    end
  end

  always_ff @(posedge clk) begin
    if (latch_en) begin
      m_tag_q   <= a_tag;
      m_idx_q   <= a_idx;
      m_off_q   <= a_off;
      m_we_q    <= cpu_we;
      m_wdata_q <= cpu_wdata;
      v_tag_q   <= lk_tag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hits_q   <= '0;
      misses_q <= '0;
    end else begin
      if (idle_hit)  hits_q   <= hits_q + CNT_W'(1);
      if (idle_miss) misses_q <= misses_q + CNT_W'(1);
    end
  end

  // CPU side
  assign cpu_stall = cpu_req && !(idle_hit || crit_beat);
  assign cpu_rdata = crit_beat ? mem_rdata : d_rdata;

  // tag store writes: invalidate on miss, install on last fill beat
  always_comb begin
    ln_we    = 1'b0;
    ln_idx   = m_idx_q;
    ln_valid = 1'b1;
    ln_dirty = m_we_q;
    ln_tag   = m_tag_q;
    if (idle_miss) begin
      ln_we    = 1'b1;
      ln_idx   = a_idx;
      ln_valid = 1'b0;
      ln_dirty = 1'b0;
      ln_tag   = a_tag;
    end else if ((state_q == ST_FILL) && mem_ready && last_beat) begin
      ln_we = 1'b1;
    end
  end
  assign mark_dirty = idle_hit && cpu_we;

  // data store ports
  assign d_ridx = (state_q == ST_IDLE) ? a_idx : m_idx_q;
  assign d_roff = (state_q == ST_IDLE) ? a_off : beat_q;

  always_comb begin
    d_we    = 1'b0;
    d_widx  = a_idx;
    d_woff  = a_off;
    d_wdata = cpu_wdata;
    if (idle_hit && cpu_we) begin
      d_we = 1'b1;
    end else if ((state_q == ST_FILL) && mem_ready) begin
      d_we    = 1'b1;
      d_widx  = m_idx_q;
      d_woff  = fill_off;
      d_wdata = (crit_beat && m_we_q) ? m_wdata_q : mem_rdata;
    end
  end

  // memory side
  assign mem_req   = (state_q != ST_IDLE);
  assign mem_we    = (state_q == ST_WB);
  assign mem_addr  = (state_q == ST_WB) ? {v_tag_q, m_idx_q, beat_q}
                                        : {m_tag_q, m_idx_q, fill_off};
  assign mem_wdata = d_rdata;

  assign hit_count  = hits_q;
  assign miss_count = misses_q;

  // R11
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                 && (!mem_we || $stable(mem_wdata))));

  // R8
  fill_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_FILL) && mem_ready && !last_beat) |=>
      (mem_req && !mem_we &&
       mem_addr[WOFF_W-1:0] == $past(mem_addr[WOFF_W-1:0]) + WOFF_W'(1)));

  // R5
  wr_hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_hit && cpu_we) |=> !mem_req);

  // R6
  wb_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_WB) && cpu_req) |-> cpu_stall);

  // R10
  hit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(hit_count) |-> (hit_count == $past(hit_count) + CNT_W'(1)));
endmodule

// File: rtl/dcache_wb.sv
module dcache_wb
  import cache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4,
  parameter int WOFF_W = 2,
  parameter int CNT_W  = 16,
  localparam int TAG_W   = ADDR_W - IDX_W - WOFF_W - 2,
  localparam int MADDR_W = ADDR_W - 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_req,
  input  logic               cpu_we,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic [WORD_W-1:0]  cpu_wdata,
  output logic [WORD_W-1:0]  cpu_rdata,
  output logic               cpu_stall,
  output logic               mem_req,
  output logic               mem_we,
  output logic [MADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0]  mem_wdata,
  input  logic               mem_ready,
  input  logic [WORD_W-1:0]  mem_rdata,
  output logic [CNT_W-1:0]   hit_count,
  output logic [CNT_W-1:0]   miss_count
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_int;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  // address split
  logic [TAG_W-1:0]  a_tag;
  logic [IDX_W-1:0]  a_idx;
  logic [WOFF_W-1:0] a_off;
  assign a_off = cpu_addr[WOFF_W+1:2];
  assign a_idx = cpu_addr[IDX_W+WOFF_W+1:WOFF_W+2];
  assign a_tag = cpu_addr[ADDR_W-1:IDX_W+WOFF_W+2];

  logic              lk_valid, lk_dirty;
  logic [TAG_W-1:0]  lk_tag;
  logic              ln_we, ln_valid, ln_dirty, mark_dirty;
  logic [IDX_W-1:0]  ln_idx;
  logic [TAG_W-1:0]  ln_tag;
  logic [IDX_W-1:0]  d_ridx, d_widx;
  logic [WOFF_W-1:0] d_roff, d_woff;
  logic [WORD_W-1:0] d_rdata, d_wdata;
  logic              d_we;

  cache_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n_int),
    .rd_idx(a_idx), .rd_valid(lk_valid), .rd_dirty(lk_dirty), .rd_tag(lk_tag),
    .ln_we(ln_we), .ln_idx(ln_idx), .ln_valid(ln_valid), .ln_dirty(ln_dirty),
    .ln_tag(ln_tag), .mark_dirty(mark_dirty), .mark_idx(a_idx)
  );

  cache_data_store #(.IDX_W(IDX_W), .WOFF_W(WOFF_W)) u_data (
    .clk(clk), .ridx(d_ridx), .roff(d_roff), .rdata(d_rdata),
    .we(d_we), .widx(d_widx), .woff(d_woff), .wdata(d_wdata)
  );

  cache_ctrl #(.IDX_W(IDX_W), .WOFF_W(WOFF_W), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n_int),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_wdata(cpu_wdata),
    .a_tag(a_tag), .a_idx(a_idx), .a_off(a_off),
    .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
    .lk_valid(lk_valid), .lk_dirty(lk_dirty), .lk_tag(lk_tag),
    .ln_we(ln_we), .ln_idx(ln_idx), .ln_valid(ln_valid), .ln_dirty(ln_dirty),
    .ln_tag(ln_tag), .mark_dirty(mark_dirty),
    .d_ridx(d_ridx), .d_roff(d_roff), .d_rdata(d_rdata),
    .d_we(d_we), .d_widx(d_widx), .d_woff(d_woff), .d_wdata(d_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .hit_count(hit_count), .miss_count(miss_count)
  );

  // R3
  reset_clean_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    $rose(rst_n_int) |-> (hit_count == '0 && miss_count == '0 && !mem_req));
endmodule

// File: tb/tb_dcache_wb.sv
module tb_dcache_wb;
  localparam int CLK_P   = 10;
  localparam int IDX_W   = 2;
  localparam int WOFF_W  = 2;
  localparam int MEM_LAT = 3;
  localparam int N_RAND  = 1500;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_req, cpu_we;
  logic [31:0] cpu_addr, cpu_wdata, cpu_rdata;
  logic        cpu_stall;
  logic        mem_req, mem_we, mem_ready;
  logic [29:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [15:0] hit_count, miss_count;

  always #(CLK_P/2) clk = ~clk;

  dcache_wb #(.IDX_W(IDX_W), .WOFF_W(WOFF_W)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_stall(cpu_stall), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
    .mem_rdata(mem_rdata), .hit_count(hit_count), .miss_count(miss_count)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // lower-level memory model and reference state
  logic [31:0] low_mem [256];
  logic [31:0] ref_mem [256];
  logic        bv [4];
  logic        bd [4];
  logic [3:0]  btag [4];
  int          exp_hits = 0, exp_miss = 0;

  logic busy = 1'b0;
  int   lat  = 0;
  always @(posedge clk) begin
    if (!busy) begin
      mem_ready <= 1'b0;
      if (mem_req) begin busy <= 1'b1; lat <= MEM_LAT; end
    end else if (lat != 0) begin
      lat <= lat - 1;
    end else if (!mem_ready) begin
      mem_ready <= 1'b1;
      mem_rdata <= low_mem[mem_addr[7:0]];
      if (mem_we) low_mem[mem_addr[7:0]] <= mem_wdata;
    end else begin
      mem_ready <= 1'b0;
      busy      <= 1'b0;
    end
  end

  // transaction monitor: beat count and refill order
  int         beats  = 0;
  logic [1:0] cur_off;
  logic [1:0] rd_beat = 2'd0;
  logic [1:0] last_off;
  always @(posedge clk) begin
    if (rst_n && mem_req && mem_ready) begin
      beats++;
      if (!mem_we) begin
        if (rd_beat == 2'd0)
          chk(mem_addr[1:0] == cur_off, "R8 critical word first", mem_addr[1:0], cur_off);
        else
          chk(mem_addr[1:0] == last_off + 2'd1, "R8 wraparound order", mem_addr[1:0], last_off + 2'd1);
        last_off = mem_addr[1:0];
        rd_beat  = rd_beat + 2'd1;
      end
    end
  end

  task automatic do_acc(input bit we, input logic [7:0] wa, input logic [31:0] wd,
                        output int stalls, output int bts);
    logic [1:0] idx, off;
    logic [3:0] tg, old_tg;
    bit         hit, evict;
    logic [31:0] pre_low, got;
    idx = wa[3:2]; off = wa[1:0]; tg = wa[7:4];
    hit    = bv[idx] && btag[idx] == tg;
    evict  = !hit && bv[idx] && bd[idx];
    old_tg = btag[idx];
    pre_low = low_mem[wa];
    if (hit) exp_hits++; else exp_miss++;
    @(negedge clk);
    cur_off   = off;
    cpu_req   = 1'b1; cpu_we = we;
    cpu_addr  = {22'd0, wa, 2'b00};
    cpu_wdata = wd;
    stalls = 0;
    #(CLK_P/4);
    while (cpu_stall) begin
      stalls++;
      @(negedge clk); #(CLK_P/4);
    end
    got = cpu_rdata;
    bts = beats + ((mem_req && mem_ready) ? 1 : 0);
    if (!we) chk(got == ref_mem[wa], "R1 read data", got, ref_mem[wa]);
    if (evict)
      for (int k = 0; k < 4; k++)
        chk(low_mem[{old_tg, idx, 2'(k)}] == ref_mem[{old_tg, idx, 2'(k)}],
            "R6 victim written back", low_mem[{old_tg, idx, 2'(k)}], ref_mem[{old_tg, idx, 2'(k)}]);
    if (we && hit) chk(low_mem[wa] == pre_low, "R5 memory untouched on write hit", low_mem[wa], pre_low);
    if (we) ref_mem[wa] = wd;
    if (!hit) begin bv[idx] = 1'b1; btag[idx] = tg; bd[idx] = we; end
    else if (we) bd[idx] = 1'b1;
    @(negedge clk);
    cpu_req = 1'b0;
  endtask

  task automatic quiet();
    repeat (60) @(negedge clk);
    beats = 0;
  endtask

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int st, bt;
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) begin
      low_mem[i] = 32'h5A00_0000 ^ (i * 32'h0001_0203);
      ref_mem[i] = 32'h5A00_0000 ^ (i * 32'h0001_0203);
    end
    for (int i = 0; i < 4; i++) begin bv[i] = 1'b0; bd[i] = 1'b0; btag[i] = '0; end
    cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0; cur_off = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #(CLK_P/4);
    chk(hit_count == 0, "R3 hit counter reset", hit_count, 0);
    chk(miss_count == 0, "R3 miss counter reset", miss_count, 0);
    chk(!mem_req && !cpu_stall, "R3 idle after reset", {mem_req, cpu_stall}, 0);

    // clean read miss at offset 2: early restart after one beat
    quiet();
    do_acc(1'b0, 8'h06, 32'h0, st, bt);
    chk(st > 0, "R3 first access misses", st, 1);
    chk(bt == 1, "R9 released on critical beat", bt, 1);
    // second access while the line tail is still filling
    do_acc(1'b0, 8'h04, 32'h0, st, bt);
    chk(st > 0, "R4 stalled during fill tail", st, 1);
    chk(bt == 4, "R4 released after full line", bt, 4);
    chk(miss_count == 1, "R10 one miss counted", miss_count, 1);

    // hit: no stall, no traffic
    quiet();
    do_acc(1'b0, 8'h07, 32'h0, st, bt);
    chk(st == 0 && bt == 0, "R2 read hit single cycle", {st, bt}, 0);
    quiet();
    do_acc(1'b1, 8'h05, 32'hDEAD_BEEF, st, bt);
    chk(st == 0 && bt == 0, "R5 write hit single cycle", {st, bt}, 0);

    // conflict on dirty line: 4 write-backs then critical read
    quiet();
    do_acc(1'b0, 8'h16, 32'h0, st, bt);
    chk(bt == 5, "R6 writeback precedes fetch", bt, 5);
    chk(low_mem[8'h05] == 32'hDEAD_BEEF, "R6 dirty word in memory", low_mem[8'h05], 32'hDEAD_BEEF);

    // write miss allocates and merges
    quiet();
    do_acc(1'b1, 8'h2B, 32'h1234_5678, st, bt);
    chk(bt == 1, "R7 write miss fetches first", bt, 1);
    quiet();
    do_acc(1'b0, 8'h2B, 32'h0, st, bt);
    chk(st == 0, "R7 merged word hits", st, 0);
    do_acc(1'b0, 8'h28, 32'h0, st, bt);
    quiet();
    do_acc(1'b0, 8'h3B, 32'h0, st, bt);
    chk(bt == 5, "R7 allocated line left dirty", bt, 5);

    // random mix
    quiet();
    for (int n = 0; n < N_RAND; n++) begin
      logic [7:0] wa;
      bit we;
      wa = 8'($urandom % 64);
      we = 1'($urandom % 2);
      do_acc(we, wa, $urandom, st, bt);
      if (($urandom % 8) == 0) repeat ($urandom % 20) @(negedge clk);
    end
    quiet();
    #(CLK_P/4);
    chk(hit_count == 16'(exp_hits), "R10 hit count", hit_count, exp_hits);
    chk(miss_count == 16'(exp_miss), "R10 miss count", miss_count, exp_miss);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule